// File: doc/BRIEF.md
# Hashed Inverted Page Table Lookup

This block translates a virtual page number into a physical frame through a table that holds one entry for each physical frame rather than one for each virtual page. The requested page number is folded by an XOR hash into a table index. The entry at that index carries a stored page tag, a frame number and a present flag. The stored tag is compared with the request to decide the outcome.

A lookup returns one of three outcomes. OK means the tag matched and the page is resident, and the physical address is driven. FAULT means the tag matched but the present flag is clear. MISS means the tag differs, and the caller must consult the full page table kept elsewhere. Each index holds a single entry and there is no chaining, so two pages that hash to the same index displace each other. A separate write port loads entries. The lookup has a fixed two-cycle latency: one cycle reads the table and one cycle registers the compare.

Top module: `ipt_lookup`

## Requirements
- R1: The table index is formed from a half-fold f = vpn[19:10] XOR vpn[9:0]. Index bit i is the XOR of every bit f[j] for which j mod 6 equals i (default widths: 20-bit page number, 6-bit index).
- R2: A lookup accepted while lk_valid is high produces rs_valid high exactly two rising edges later. rs_valid is low in every other cycle.
- R3: When the indexed tag equals the requested page and the present flag is set, rs_ok is high and rs_paddr equals {frame, offset}. The frame sits in the upper 10 bits and the unmodified 12-bit offset sits in the lower bits.
- R4: When the indexed tag equals the requested page but the present flag is clear, rs_fault is high and rs_paddr is zero.
- R5: When the indexed tag differs from the requested page, rs_miss is high and rs_paddr is zero, whatever the present flag holds.
- R6: While rs_valid is high, exactly one of rs_ok, rs_fault and rs_miss is high. While it is low, all three are low.
- R7: A write and a lookup to the same index in the same cycle give the lookup the old entry. A later lookup sees the new entry.
- R8: Reset clears every present flag and all result outputs, and it leaves the stored tags in place. A lookup after reset therefore never returns OK until its entry is rewritten.
- R9: Writing a second page whose hash collides with a loaded page replaces that entry. The first page then misses.
- R10: Lookups may be issued on consecutive cycles. Each lookup returns its own result, in issue order, two cycles after it was issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_ofs | input | 12 | Page offset carried through to the result |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 6 | Table index to load |
| wr_tag | input | 20 | Page tag to store |
| wr_frame | input | 10 | Frame number to store |
| wr_present | input | 1 | Present flag to store |
| rs_valid | output | 1 | Result valid |
| rs_ok | output | 1 | Resident translation found |
| rs_fault | output | 1 | Tag matched, page not present |
| rs_miss | output | 1 | Tag mismatch, use the full page table |
| rs_paddr | output | 22 | Physical address {frame, offset}, zero unless OK |

## Verification
The assertions take for granted that lk_valid, lk_ofs and the write strobe are driven to known levels on every cycle after reset. They also assume the offset presented with a request is the one the result must echo. They do not assume that any table entry has been written. For that reason they check only the outcome encoding, the latency and the address framing, and never the hit value itself. The stimulus drives every input at the falling edge and holds lk_valid low between requests unless a back-to-back burst is intended. It also looks up only indices the bench has loaded, except for the post-reset checks, where only the non-OK outcome is predicted.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

  typedef enum logic [1:0] {
    OUT_MISS  = 2'd0,
    OUT_FAULT = 2'd1,
    OUT_OK    = 2'd2
  } outcome_e;

endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int VPN_W = 20,
  parameter int IDX_W = 6
) (
  input  logic [VPN_W-1:0] vpn_i,
  output logic [IDX_W-1:0] idx_o
);

  localparam int HALF   = VPN_W / 2;
  localparam int FOLD_W = VPN_W - HALF;

  logic [FOLD_W-1:0] fold;

  // upper half folded onto lower half
  for (genvar j = 0; j < FOLD_W; j++) begin : g_fold
    if (j < HALF) begin : g_pair
      assign fold[j] = vpn_i[HALF+j] ^ vpn_i[j];
    end else begin : g_single
      assign fold[j] = vpn_i[HALF+j];
    end
  end

  // reduce the fold to the index width modulo IDX_W
  always_comb begin
    idx_o = '0;
    for (int j = 0; j < FOLD_W; j++) begin
      idx_o[j % IDX_W] = idx_o[j % IDX_W] ^ fold[j];
    end
  end

endmodule

// File: rtl/ipt_store.sv
module ipt_store #(
  parameter int VPN_W   = 20,
  parameter int OFS_W   = 12,
  parameter int FRAME_W = 10,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid_i,
  input  logic [IDX_W-1:0]   lk_idx_i,
  input  logic [VPN_W-1:0]   lk_vpn_i,
  input  logic [OFS_W-1:0]   lk_ofs_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [VPN_W-1:0]   wr_tag_i,
  input  logic [FRAME_W-1:0] wr_frame_i,
  input  logic               wr_present_i,
  output logic               s1_valid_o,
  output logic [VPN_W-1:0]   s1_vpn_o,
  output logic [OFS_W-1:0]   s1_ofs_o,
  output logic [VPN_W-1:0]   s1_tag_o,
  output logic [FRAME_W-1:0] s1_frame_o,
  output logic               s1_pres_o
);

  localparam int DEPTH = 1 << IDX_W;

  logic [VPN_W-1:0]   tag_mem [DEPTH];
  logic [FRAME_W-1:0] frm_mem [DEPTH];
  logic [DEPTH-1:0]   pres_q, pres_d;
  logic               s1_pres_d;

  // present flags: next state
  always_comb begin
    pres_d = pres_q;
    if (wr_en_i) begin
      pres_d[wr_idx_i] = wr_present_i;
    end
  end

  always_comb begin
    s1_pres_d = s1_pres_o;
    if (lk_valid_i) begin
      s1_pres_d = pres_q[lk_idx_i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q     <= '0;
      s1_valid_o <= 1'b0;
      s1_pres_o  <= 1'b0;
    end else begin
      pres_q     <= pres_d;
      s1_valid_o <= lk_valid_i;
      s1_pres_o  <= s1_pres_d;
    end
  end

  // tag and frame storage, no reset
  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      tag_mem[wr_idx_i] <= wr_tag_i;
      frm_mem[wr_idx_i] <= wr_frame_i;
    end
  end

  // registered read; same-edge write is not visible here
  always_ff @(posedge clk) begin
    if (lk_valid_i) begin
      s1_tag_o   <= tag_mem[lk_idx_i];
      s1_frame_o <= frm_mem[lk_idx_i];
      s1_vpn_o   <= lk_vpn_i;
      s1_ofs_o   <= lk_ofs_i;
    end
  end

endmodule

// File: rtl/ipt_compare.sv
module ipt_compare
  import ipt_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int OFS_W   = 12,
  parameter int FRAME_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s1_valid_i,
  input  logic [VPN_W-1:0]         s1_vpn_i,
  input  logic [OFS_W-1:0]         s1_ofs_i,
  input  logic [VPN_W-1:0]         s1_tag_i,
  input  logic [FRAME_W-1:0]       s1_frame_i,
  input  logic                     s1_pres_i,
  output logic                     rs_valid_o,
  output logic                     rs_ok_o,
  output logic                     rs_fault_o,
  output logic                     rs_miss_o,
  output logic [FRAME_W+OFS_W-1:0] rs_paddr_o
);

  localparam int PA_W = FRAME_W + OFS_W;

  outcome_e        outcome;
  logic            valid_d, ok_d, fault_d, miss_d;
  logic [PA_W-1:0] paddr_d;

  always_comb begin
    if (s1_tag_i != s1_vpn_i) begin
      outcome = OUT_MISS;
    end else if (s1_pres_i) begin
      outcome = OUT_OK;
    end else begin
      outcome = OUT_FAULT;
    end
  end

  always_comb begin
    valid_d = s1_valid_i;
    ok_d    = s1_valid_i && (outcome == OUT_OK);
    fault_d = s1_valid_i && (outcome == OUT_FAULT);
    miss_d  = s1_valid_i && (outcome == OUT_MISS);
    paddr_d = ok_d ? {s1_frame_i, s1_ofs_i} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid_o <= 1'b0;
      rs_ok_o    <= 1'b0;
      rs_fault_o <= 1'b0;
      rs_miss_o  <= 1'b0;
      rs_paddr_o <= '0;
    end else begin
      rs_valid_o <= valid_d;
      rs_ok_o    <= ok_d;
      rs_fault_o <= fault_d;
      rs_miss_o  <= miss_d;
      rs_paddr_o <= paddr_d;
    end
  end

endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
  parameter int VPN_W   = 20,
  parameter int OFS_W   = 12,
  parameter int FRAME_W = 10,
  parameter int IDX_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_valid,
  input  logic [VPN_W-1:0]         lk_vpn,
  input  logic [OFS_W-1:0]         lk_ofs,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [VPN_W-1:0]         wr_tag,
  input  logic [FRAME_W-1:0]       wr_frame,
  input  logic                     wr_present,
  output logic                     rs_valid,
  output logic                     rs_ok,
  output logic                     rs_fault,
  output logic                     rs_miss,
  output logic [FRAME_W+OFS_W-1:0] rs_paddr
);

  logic [IDX_W-1:0]   lk_idx;
  logic               s1_valid, s1_pres;
  logic [VPN_W-1:0]   s1_vpn, s1_tag;
  logic [OFS_W-1:0]   s1_ofs;
  logic [FRAME_W-1:0] s1_frame;

  ipt_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_hash (
    .vpn_i (lk_vpn),
    .idx_o (lk_idx)
  );

  ipt_store #(
    .VPN_W(VPN_W), .OFS_W(OFS_W), .FRAME_W(FRAME_W), .IDX_W(IDX_W)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid_i   (lk_valid),
    .lk_idx_i     (lk_idx),
    .lk_vpn_i     (lk_vpn),
    .lk_ofs_i     (lk_ofs),
    .wr_en_i      (wr_en),
    .wr_idx_i     (wr_idx),
    .wr_tag_i     (wr_tag),
    .wr_frame_i   (wr_frame),
    .wr_present_i (wr_present),
    .s1_valid_o   (s1_valid),
    .s1_vpn_o     (s1_vpn),
    .s1_ofs_o     (s1_ofs),
    .s1_tag_o     (s1_tag),
    .s1_frame_o   (s1_frame),
    .s1_pres_o    (s1_pres)
  );

  ipt_compare #(
    .VPN_W(VPN_W), .OFS_W(OFS_W), .FRAME_W(FRAME_W)
  ) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .s1_valid_i (s1_valid),
    .s1_vpn_i   (s1_vpn),
    .s1_ofs_i   (s1_ofs),
    .s1_tag_i   (s1_tag),
    .s1_frame_i (s1_frame),
    .s1_pres_i  (s1_pres),
    .rs_valid_o (rs_valid),
    .rs_ok_o    (rs_ok),
    .rs_fault_o (rs_fault),
    .rs_miss_o  (rs_miss),
    .rs_paddr_o (rs_paddr)
  );

endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
  parameter int OFS_W   = 12,
  parameter int FRAME_W = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     lk_valid,
  input logic [OFS_W-1:0]         lk_ofs,
  input logic                     rs_valid,
  input logic                     rs_ok,
  input logic                     rs_fault,
  input logic                     rs_miss,
  input logic [FRAME_W+OFS_W-1:0] rs_paddr
);

  logic             v1, v2;
  logic [OFS_W-1:0] o1, o2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= lk_valid;
      v2 <= v1;
    end
  end

  always_ff @(posedge clk) begin
    o1 <= lk_ofs;
    o2 <= o1;
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid == v2);

  assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> $countones({rs_ok, rs_fault, rs_miss}) == 1);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |-> !(rs_ok || rs_fault || rs_miss));

  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rs_ok |-> rs_paddr[OFS_W-1:0] == o2);

  assert_fault_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rs_fault |-> rs_paddr == '0);

  assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rs_miss |-> rs_paddr == '0);

endmodule

bind ipt_lookup ipt_lookup_chk #(.OFS_W(OFS_W), .FRAME_W(FRAME_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lk_valid (lk_valid),
  .lk_ofs   (lk_ofs),
  .rs_valid (rs_valid),
  .rs_ok    (rs_ok),
  .rs_fault (rs_fault),
  .rs_miss  (rs_miss),
  .rs_paddr (rs_paddr)
);

// File: tb/test_ipt_lookup.sv
module test_ipt_lookup;

  localparam int VW = 20;
  localparam int OW = 12;
  localparam int FW = 10;
  localparam int IW = 6;
  localparam int PW = FW + OW;

  typedef struct packed {
    logic          load;
    logic          pres;
    logic [VW-1:0] vpn;
    logic [OW-1:0] ofs;
    logic [FW-1:0] frame;
  } row_t;

  localparam row_t ROWS [8] = '{
    '{1'b1, 1'b1, 20'h12345, 12'h0AB, 10'h155},
    '{1'b1, 1'b1, 20'hABCDE, 12'hFFF, 10'h3FF},
    '{1'b1, 1'b0, 20'h0F0F0, 12'h000, 10'h001},
    '{1'b0, 1'b0, 20'h12744, 12'h123, 10'h000},
    '{1'b1, 1'b1, 20'h00000, 12'h800, 10'h000},
    '{1'b1, 1'b1, 20'hFFFFF, 12'h7FF, 10'h2AA},
    '{1'b0, 1'b0, 20'h00000, 12'h001, 10'h000},
    '{1'b0, 1'b0, 20'h12345, 12'hFED, 10'h000}
  };

  logic          clk;
  logic          rst_n;
  logic          lk_valid;
  logic [VW-1:0] lk_vpn;
  logic [OW-1:0] lk_ofs;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [VW-1:0] wr_tag;
  logic [FW-1:0] wr_frame;
  logic          wr_present;
  logic          rs_valid, rs_ok, rs_fault, rs_miss;
  logic [PW-1:0] rs_paddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [VW-1:0] m_tag  [1<<IW];
  logic [FW-1:0] m_frm  [1<<IW];
  logic          m_pres [1<<IW];

  ipt_lookup i_ipt_lookup (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_ofs(lk_ofs),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_frame(wr_frame), .wr_present(wr_present),
    .rs_valid(rs_valid), .rs_ok(rs_ok), .rs_fault(rs_fault),
    .rs_miss(rs_miss), .rs_paddr(rs_paddr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // R1: half-fold then modulo-6 XOR reduction
  function automatic logic [IW-1:0] bhash(input logic [VW-1:0] v);
    logic [9:0]    f;
    logic [IW-1:0] r;
    f = v[19:10] ^ v[9:0];
    r = '0;
    for (int j = 0; j < 10; j++) r[j % IW] = r[j % IW] ^ f[j];
    return r;
  endfunction

  // result vector {valid, ok, fault, miss, paddr}
  function automatic logic [PW+3:0] predict(input logic [VW-1:0] v, input logic [OW-1:0] o);
    logic [IW-1:0] ix;
    ix = bhash(v);
    if (m_tag[ix] != v) return {4'b1001, {PW{1'b0}}};
    if (!m_pres[ix])    return {4'b1010, {PW{1'b0}}};
    return {4'b1100, m_frm[ix], o};
  endfunction

  function automatic string kind_req(input logic [PW+3:0] e);
    if (e[PW+2]) return "R3";
    if (e[PW+1]) return "R4";
    return "R5";
  endfunction

  function automatic logic [PW+3:0] observed();
    return {rs_valid, rs_ok, rs_fault, rs_miss, rs_paddr};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [IW-1:0] ix, input logic [VW-1:0] t,
                          input logic [FW-1:0] fr, input logic p);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = ix; wr_tag = t; wr_frame = fr; wr_present = p;
    @(negedge clk);
    wr_en = 1'b0;
    m_tag[ix] = t; m_frm[ix] = fr; m_pres[ix] = p;
  endtask

  task automatic do_lookup(input logic [VW-1:0] v, input logic [OW-1:0] o,
                           output logic [PW+3:0] res);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v; lk_ofs = o;
    @(negedge clk);
    lk_valid = 1'b0;
    @(negedge clk);
    res = observed();
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R2 got=running exp=finished");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [PW+3:0] got, e;
    logic [PW+3:0] bb_exp [4];
    logic [IW-1:0] cix;

    rst_n = 1'b0; lk_valid = 1'b0; lk_vpn = '0; lk_ofs = '0;
    wr_en = 1'b0; wr_idx = '0; wr_tag = '0; wr_frame = '0; wr_present = 1'b0;
    for (int i = 0; i < (1<<IW); i++) begin
      m_tag[i] = '0; m_frm[i] = '0; m_pres[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: outputs quiet after reset, no OK before any load
    check("R8 reset outputs", 32'(observed()), 32'd0);
    do_lookup(20'h12345, 12'h000, got);
    check("R8 no hit after reset", {30'd0, got[PW+3], got[PW+2]}, 32'h2);

    // table walk: R1 index, R3/R4/R5 outcomes, R6 encoding, R9 collision
    for (int r = 0; r < 8; r++) begin
      if (ROWS[r].load)
        do_write(bhash(ROWS[r].vpn), ROWS[r].vpn, ROWS[r].frame, ROWS[r].pres);
      e = predict(ROWS[r].vpn, ROWS[r].ofs);
      do_lookup(ROWS[r].vpn, ROWS[r].ofs, got);
      check($sformatf("R1 R6 R9 %s row %0d", kind_req(e), r), 32'(got), 32'(e));
    end

    // R2: latency, valid only on the second edge
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = 20'h12345; lk_ofs = 12'h055;
    @(negedge clk);
    lk_valid = 1'b0;
    check("R2 one edge", {31'd0, rs_valid}, 32'd0);
    @(negedge clk);
    check("R2 two edges", {31'd0, rs_valid}, 32'd1);
    @(negedge clk);
    check("R2 single pulse", {31'd0, rs_valid}, 32'd0);

    // R10: back-to-back lookups in order
    for (int k = 0; k < 4; k++) bb_exp[k] = predict(ROWS[k].vpn, ROWS[k].ofs);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k >= 2) check($sformatf("R10 burst %0d", k - 2), 32'(observed()), 32'(bb_exp[k-2]));
      if (k < 4) begin
        lk_valid = 1'b1; lk_vpn = ROWS[k].vpn; lk_ofs = ROWS[k].ofs;
      end else begin
        lk_valid = 1'b0;
      end
    end

    // R7: same-cycle write and lookup to one index
    cix = bhash(20'h12345);
    e = predict(20'h12345, 12'h010);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = 20'h12345; lk_ofs = 12'h010;
    wr_en = 1'b1; wr_idx = cix; wr_tag = 20'h55555; wr_frame = 10'h0C3; wr_present = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0; wr_en = 1'b0;
    m_tag[cix] = 20'h55555; m_frm[cix] = 10'h0C3; m_pres[cix] = 1'b1;
    @(negedge clk);
    check("R7 old contents", 32'(observed()), 32'(e));
    e = predict(20'h12345, 12'h010);
    do_lookup(20'h12345, 12'h010, got);
    check("R7 new contents", 32'(got), 32'(e));

    // R8: reset mid-run clears present flags, tags remain
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 async clear", 32'(observed()), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < (1<<IW); i++) m_pres[i] = 1'b0;
    e = predict(20'hFFFFF, 12'h7FF);
    do_lookup(20'hFFFFF, 12'h7FF, got);
    check("R8 fault after reset", 32'(got), 32'(e));

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule